// File: doc/BRIEF.md
# Machine-Mode Interrupt Control Register File

This block keeps the machine-level interrupt and trap control state of a 32-bit RISC-V hart. The instruction pipeline reaches it through one CSR access port. Each access names a 12-bit CSR address and an operation: plain read, write, bit-set or bit-clear. The port returns the register's value from before the access in the same cycle. Any change shows from the next clock edge.

Three level-sensitive interrupt lines (software, timer, external) are registered into read-only pending bits. The pending bits, the per-source enables and the global enable go to the trap controller, which decides when to take an interrupt. When it takes one, the controller pulses a trap-entry strobe with the interrupted PC and the interrupt code. The block then records the return address and the cause, and it saves and clears the global enable in hardware. A return strobe undoes the status change. The handler base, the vectored-mode flag and the saved return address go to the program-counter logic.

Top module: `mcsr_irq_file`

## Requirements
- R1: The access operation is encoded on `csr_op` as 00 read only, 01 write, 10 set bits given by `csr_wdata`, and 11 clear bits given by `csr_wdata`. `csr_rdata` shows the addressed register's value from before the access in the same cycle. The new value takes effect at the next clock edge.
- R2: Register addresses are 0x300 status, 0x304 enable, 0x305 trap vector, 0x341 return PC, 0x342 cause, 0x343 trap value and 0x344 pending.
- R3: Pending register 0x344 holds the software input at bit 3, the timer input at bit 7 and the external input at bit 11. Each bit is the input as sampled at the previous clock edge. Software writes to this register are ignored. `irq_pend_o` carries the same bits as {external, timer, software}.
- R4: Enable register 0x304 stores bits 3 (software), 7 (timer) and 11 (external). All other bits read zero. `irq_en_o` carries the stored bits as {external, timer, software}.
- R5: Status register 0x300 stores the global enable at bit 3 and the previous-enable copy at bit 7. All other bits read zero. `glb_ie_o` carries bit 3.
- R6: In the cycle after a `trap_enter` pulse, bit 7 of status holds the old bit 3, bit 3 is 0, the return PC holds `trap_pc`, and cause holds bit 31 = 1 with `trap_code` in bits 30:0. A software write to any of these registers in the same cycle loses.
- R7: In the cycle after an `mret` pulse, status bit 3 holds the old bit 7 and bit 7 is 1. If `trap_enter` is asserted in the same cycle, trap entry takes effect and the return is dropped.
- R8: Trap vector 0x305 stores the base in bits 31:2 and the mode in bit 0 (0 direct, 1 vectored). Bit 1 reads zero. `tvec_base_o` is the base with bits 1:0 zero, and `tvec_vectored_o` is mode bit 0.
- R9: Trap value 0x343 is a full 32-bit register that only software changes. Trap entry leaves it unchanged.
- R10: An access with `csr_req` high to any other address returns zero, drives `csr_illegal` high in the same cycle and changes no register. With `csr_req` low, `csr_illegal` is low.
- R11: Synchronous active-low reset clears every register, every pending bit and every output to zero.
- R12: Return PC 0x341 and cause 0x342 are full 32-bit registers that software can read and write. `epc_o` carries the return PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_req | input | 1 | CSR access valid this cycle |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| csr_wdata | input | 32 | Write data or bit mask |
| csr_rdata | output | 32 | Value of the register before the access |
| csr_illegal | output | 1 | Access to an unimplemented address |
| irq_sw_i | input | 1 | Software interrupt level |
| irq_tmr_i | input | 1 | Timer interrupt level |
| irq_ext_i | input | 1 | External interrupt level |
| trap_enter | input | 1 | Trap entry strobe from the controller |
| trap_pc | input | 32 | PC to save on trap entry |
| trap_code | input | 31 | Interrupt code to record on trap entry |
| mret | input | 1 | Trap return strobe |
| irq_pend_o | output | 3 | Pending bits {ext, tmr, sw} |
| irq_en_o | output | 3 | Enable bits {ext, tmr, sw} |
| glb_ie_o | output | 1 | Global interrupt enable |
| tvec_base_o | output | 32 | Handler base address |
| tvec_vectored_o | output | 1 | Vectored mode selected |
| epc_o | output | 32 | Saved return PC |

## Verification
A wrong status update on trap entry or return shows on `glb_ie_o` and on a status read one cycle after the strobe. A lost priority between hardware and software shows as a software value surviving a trap that happened in the same cycle. A stuck or wrongly placed pending or enable bit shows on the exported vectors and on a register read in the next cycle. A wrong read-modify-write result shows on the read that follows the access.

// File: rtl/mcsr_pkg.sv
// Shared constants and types for the machine interrupt register file.
// Assumes a 32-bit hart and 12-bit CSR addresses.
package mcsr_pkg;
    localparam int XLEN    = 32;
    localparam int AW      = 12;
    localparam int NUM_SRC = 3;

    localparam logic [AW-1:0] A_STATUS = 12'h300;
    localparam logic [AW-1:0] A_IE     = 12'h304;
    localparam logic [AW-1:0] A_TVEC   = 12'h305;
    localparam logic [AW-1:0] A_EPC    = 12'h341;
    localparam logic [AW-1:0] A_CAUSE  = 12'h342;
    localparam logic [AW-1:0] A_TVAL   = 12'h343;
    localparam logic [AW-1:0] A_IP     = 12'h344;

    localparam int B_GIE = 3;
    localparam int B_PIE = 7;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    // Bit position of interrupt source i (0 sw, 1 timer, 2 external).
    function automatic int src_bit(input int i);
        return 3 + 4 * i;
    endfunction
endpackage

// File: rtl/mcsr_wval.sv
// Read-modify-write unit: produces the value an access would store.
// Assumes old_val is the current content of the addressed register.
module mcsr_wval
    import mcsr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] new_val,
    output logic         wr
);
    // Select the next value from the operation code.
    always_comb begin
        wr      = 1'b1;
        new_val = old_val;
        case (csr_op_e'(op))
            OP_WRITE: new_val = wdata;
            OP_SET:   new_val = old_val | wdata;
            OP_CLEAR: new_val = old_val & ~wdata;
            default:  wr = 1'b0;
        endcase
    end
endmodule

// File: rtl/mcsr_pending.sv
// Registers the interrupt request levels into pending flags.
// Assumes the inputs are already synchronous to clk.
module mcsr_pending #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_src
        // Capture one request line per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_o[g] <= 1'b0;
            else        pend_o[g] <= src_i[g];
        end
    end
endmodule

// File: rtl/mcsr_status.sv
// Global enable and previous-enable flags with hardware trap updates.
// Priority: trap entry, then return, then software write.
module mcsr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_we,
    input  logic sw_gie,
    input  logic sw_pie,
    input  logic trap_enter,
    input  logic mret,
    output logic gie_o,
    output logic pie_o
);
    // Update both flags together from the highest-priority source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_o <= 1'b0;
            pie_o <= 1'b0;
        end else if (trap_enter) begin
            pie_o <= gie_o;
            gie_o <= 1'b0;
        end else if (mret) begin
            gie_o <= pie_o;
            pie_o <= 1'b1;
        end else if (sw_we) begin
            gie_o <= sw_gie;
            pie_o <= sw_pie;
        end
    end
endmodule

// File: rtl/mcsr_irq_file.sv
// Machine-mode interrupt CSR file: address decode, read mux, software
// access and hardware trap-entry and return updates.
// Assumes trap_enter and mret are single-cycle strobes from the controller.
module mcsr_irq_file
    import mcsr_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int NS = NUM_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_req,
    input  logic [AW-1:0] csr_addr,
    input  logic [1:0]    csr_op,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    output logic          csr_illegal,
    input  logic          irq_sw_i,
    input  logic          irq_tmr_i,
    input  logic          irq_ext_i,
    input  logic          trap_enter,
    input  logic [DW-1:0] trap_pc,
    input  logic [DW-2:0] trap_code,
    input  logic          mret,
    output logic [NS-1:0] irq_pend_o,
    output logic [NS-1:0] irq_en_o,
    output logic          glb_ie_o,
    output logic [DW-1:0] tvec_base_o,
    output logic          tvec_vectored_o,
    output logic [DW-1:0] epc_o
);
    logic [NS-1:0]   pend;
    logic [NS-1:0]   ie_q;
    logic            status_gie;
    logic            status_pie;
    logic [DW-1:2]   tvec_base_q;
    logic            tvec_mode_q;
    logic [DW-1:0]   epc_q;
    logic [DW-1:0]   cause_q;
    logic [DW-1:0]   tval_q;
    logic [DW-1:0]   rd;
    logic            hit;
    logic [DW-1:0]   new_val;
    logic            wr;
    logic            acc_wr;

    mcsr_pending #(.N(NS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  ({irq_ext_i, irq_tmr_i, irq_sw_i}),
        .pend_o (pend)
    );

    // Select the register content for the addressed CSR.
    always_comb begin
        rd  = '0;
        hit = 1'b1;
        case (csr_addr)
            A_STATUS: begin
                rd[B_GIE] = status_gie;
                rd[B_PIE] = status_pie;
            end
            A_IE:     for (int i = 0; i < NS; i++) rd[src_bit(i)] = ie_q[i];
            A_IP:     for (int i = 0; i < NS; i++) rd[src_bit(i)] = pend[i];
            A_TVEC:   rd = {tvec_base_q, 1'b0, tvec_mode_q};
            A_EPC:    rd = epc_q;
            A_CAUSE:  rd = cause_q;
            A_TVAL:   rd = tval_q;
            default:  hit = 1'b0;
        endcase
    end

    assign csr_rdata   = rd;
    assign csr_illegal = csr_req && !hit;

    mcsr_wval #(.W(DW)) u_wval (
        .op      (csr_op),
        .old_val (rd),
        .wdata   (csr_wdata),
        .new_val (new_val),
        .wr      (wr)
    );

    assign acc_wr = csr_req && wr;

    mcsr_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we      (acc_wr && csr_addr == A_STATUS),
        .sw_gie     (new_val[B_GIE]),
        .sw_pie     (new_val[B_PIE]),
        .trap_enter (trap_enter),
        .mret       (mret),
        .gie_o      (status_gie),
        .pie_o      (status_pie)
    );

    // Per-source enable bits, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= '0;
        else if (acc_wr && csr_addr == A_IE)
            for (int i = 0; i < NS; i++) ie_q[i] <= new_val[src_bit(i)];
    end

    // Trap vector base and mode, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tvec_base_q <= '0;
            tvec_mode_q <= 1'b0;
        end else if (acc_wr && csr_addr == A_TVEC) begin
            tvec_base_q <= new_val[DW-1:2];
            tvec_mode_q <= new_val[0];
        end
    end

    // Return PC: trap entry wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          epc_q <= '0;
        else if (trap_enter)                 epc_q <= trap_pc;
        else if (acc_wr && csr_addr == A_EPC) epc_q <= new_val;
    end

    // Cause: trap entry records an interrupt cause, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cause_q <= '0;
        else if (trap_enter)                   cause_q <= {1'b1, trap_code};
        else if (acc_wr && csr_addr == A_CAUSE) cause_q <= new_val;
    end

    // Trap value: software scratch register, no hardware update.
    always_ff @(posedge clk) begin
        if (!rst_n)                           tval_q <= '0;
        else if (acc_wr && csr_addr == A_TVAL) tval_q <= new_val;
    end

    assign irq_pend_o      = pend;
    assign irq_en_o        = ie_q;
    assign glb_ie_o        = status_gie;
    assign tvec_base_o     = {tvec_base_q, 2'b00};
    assign tvec_vectored_o = tvec_mode_q;
    assign epc_o           = epc_q;
endmodule

// File: rtl/mcsr_irq_file_chk.sv
// Checker for the interrupt register file, attached by bind.
// Assumes the bound instance uses the default parameters.
module mcsr_irq_file_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_req,
    input logic        csr_illegal,
    input logic [31:0] csr_rdata,
    input logic        irq_sw_i,
    input logic        irq_tmr_i,
    input logic        irq_ext_i,
    input logic [2:0]  irq_pend_o,
    input logic        trap_enter,
    input logic [31:0] trap_pc,
    input logic [30:0] trap_code,
    input logic        mret,
    input logic        glb_ie_o,
    input logic [31:0] epc_o,
    input logic        pie,
    input logic [31:0] cause
);
    assert_trap_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> !glb_ie_o && pie == $past(glb_ie_o));

    assert_trap_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> epc_o == $past(trap_pc) && cause == {1'b1, $past(trap_code)});

    assert_mret_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && !trap_enter) |=> glb_ie_o == $past(pie) && pie);

    assert_pend_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_pend_o == $past({irq_ext_i, irq_tmr_i, irq_sw_i}));

    assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_req && csr_rdata == 32'h0);
endmodule

bind mcsr_irq_file mcsr_irq_file_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_req     (csr_req),
    .csr_illegal (csr_illegal),
    .csr_rdata   (csr_rdata),
    .irq_sw_i    (irq_sw_i),
    .irq_tmr_i   (irq_tmr_i),
    .irq_ext_i   (irq_ext_i),
    .irq_pend_o  (irq_pend_o),
    .trap_enter  (trap_enter),
    .trap_pc     (trap_pc),
    .trap_code   (trap_code),
    .mret        (mret),
    .glb_ie_o    (glb_ie_o),
    .epc_o       (epc_o),
    .pie         (status_pie),
    .cause       (cause_q)
);

// File: tb/tb_mcsr_irq_file.sv
module tb_mcsr_irq_file;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;
    // Entry: addr[82:71] op[70:69] wdata[68:37] exp_rdata[36:5] exp_ill[4] req[3:0]
    localparam logic [82:0] VEC [NV] = '{
        {12'h304, 2'd1, 32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd1},
        {12'h304, 2'd0, 32'h00000000, 32'h00000888, 1'b0, 4'd4},
        {12'h304, 2'd3, 32'h00000008, 32'h00000888, 1'b0, 4'd1},
        {12'h304, 2'd0, 32'h00000000, 32'h00000880, 1'b0, 4'd4},
        {12'h300, 2'd2, 32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd1},
        {12'h300, 2'd0, 32'h00000000, 32'h00000088, 1'b0, 4'd5},
        {12'h300, 2'd3, 32'h00000080, 32'h00000088, 1'b0, 4'd1},
        {12'h300, 2'd0, 32'h00000000, 32'h00000008, 1'b0, 4'd5},
        {12'h305, 2'd1, 32'h12345677, 32'h00000000, 1'b0, 4'd8},
        {12'h305, 2'd0, 32'h00000000, 32'h12345675, 1'b0, 4'd8},
        {12'h343, 2'd1, 32'hDEADBEEF, 32'h00000000, 1'b0, 4'd9},
        {12'h343, 2'd2, 32'h00000010, 32'hDEADBEEF, 1'b0, 4'd1},
        {12'h343, 2'd0, 32'h00000000, 32'hDEADBEFF, 1'b0, 4'd9},
        {12'h341, 2'd1, 32'h00001000, 32'h00000000, 1'b0, 4'd12},
        {12'h342, 2'd1, 32'h8000000B, 32'h00000000, 1'b0, 4'd12},
        {12'h342, 2'd0, 32'h00000000, 32'h8000000B, 1'b0, 4'd12},
        {12'h344, 2'd1, 32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd3},
        {12'h344, 2'd0, 32'h00000000, 32'h00000000, 1'b0, 4'd3},
        {12'h7C0, 2'd1, 32'h00000001, 32'h00000000, 1'b1, 4'd10},
        {12'h7C0, 2'd0, 32'h00000000, 32'h00000000, 1'b1, 4'd10},
        {12'h341, 2'd0, 32'h00000000, 32'h00001000, 1'b0, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        irq_sw_i = 1'b0, irq_tmr_i = 1'b0, irq_ext_i = 1'b0;
    logic        trap_enter = 1'b0;
    logic [31:0] trap_pc = '0;
    logic [30:0] trap_code = '0;
    logic        mret = 1'b0;
    logic [2:0]  irq_pend_o, irq_en_o;
    logic        glb_ie_o, tvec_vectored_o;
    logic [31:0] tvec_base_o, epc_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mcsr_irq_file dut (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .irq_sw_i(irq_sw_i), .irq_tmr_i(irq_tmr_i),
        .irq_ext_i(irq_ext_i), .trap_enter(trap_enter), .trap_pc(trap_pc),
        .trap_code(trap_code), .mret(mret), .irq_pend_o(irq_pend_o),
        .irq_en_o(irq_en_o), .glb_ie_o(glb_ie_o), .tvec_base_o(tvec_base_o),
        .tvec_vectored_o(tvec_vectored_o), .epc_o(epc_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access: drive at falling edge, sample combinational result, clock it.
    task automatic acc(input logic [11:0] a, input logic [1:0] o, input logic [31:0] w,
                       output logic [31:0] rdv, output logic ill);
        @(negedge clk);
        csr_req = 1'b1; csr_addr = a; csr_op = o; csr_wdata = w;
        #1;
        rdv = csr_rdata; ill = csr_illegal;
        @(posedge clk); #1;
        csr_req = 1'b0; csr_op = 2'd0; csr_wdata = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v; logic il;
        acc(a, 2'd0, 32'h0, v, il);
        check(tag, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v; logic il;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11: reset state
        check("R11 glb_ie", {31'h0, glb_ie_o}, 32'h0);
        check("R11 irq_en", {29'h0, irq_en_o}, 32'h0);
        check("R11 tvec_base", tvec_base_o, 32'h0);
        check("R11 epc", epc_o, 32'h0);
        rd_chk(12'h300, 32'h0, "R11 status");
        rd_chk(12'h343, 32'h0, "R11 tval");

        // Table walk: R1 read-modify-write and R2 address map
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][82:71], VEC[i][70:69], VEC[i][68:37], v, il);
            check($sformatf("R%0d vec%0d rdata", VEC[i][3:0], i), v, VEC[i][36:5]);
            check($sformatf("R%0d vec%0d illegal", VEC[i][3:0], i), {31'h0, il}, {31'h0, VEC[i][4]});
        end

        // Exported views after the table
        @(negedge clk);
        check("R4 irq_en", {29'h0, irq_en_o}, 32'h6);
        check("R5 glb_ie", {31'h0, glb_ie_o}, 32'h1);
        check("R8 tvec_base", tvec_base_o, 32'h12345674);
        check("R8 vectored", {31'h0, tvec_vectored_o}, 32'h1);
        check("R12 epc_o", epc_o, 32'h1000);
        check("R10 idle illegal", {31'h0, csr_illegal}, 32'h0);

        // R3: pending follows the inputs one edge later; writes ignored
        irq_tmr_i = 1'b1;
        @(posedge clk); #1;
        check("R3 pend tmr", {29'h0, irq_pend_o}, 32'h2);
        rd_chk(12'h344, 32'h80, "R3 pend read tmr");
        irq_sw_i = 1'b1; irq_ext_i = 1'b1;
        acc(12'h344, 2'd3, 32'hFFFFFFFF, v, il);
        rd_chk(12'h344, 32'h888, "R3 pend clear ignored");
        irq_sw_i = 1'b0; irq_tmr_i = 1'b0; irq_ext_i = 1'b0;
        @(posedge clk); #1;
        check("R3 pend drop", {29'h0, irq_pend_o}, 32'h0);

        // R6: trap entry beats a same-cycle software status write
        @(negedge clk);
        trap_enter = 1'b1; trap_pc = 32'h2004; trap_code = 31'd7;
        csr_req = 1'b1; csr_addr = 12'h300; csr_op = 2'd1; csr_wdata = 32'h88;
        @(posedge clk); #1;
        trap_enter = 1'b0; csr_req = 1'b0; csr_op = 2'd0;
        check("R6 glb_ie cleared", {31'h0, glb_ie_o}, 32'h0);
        rd_chk(12'h300, 32'h80, "R6 status after trap");
        rd_chk(12'h341, 32'h2004, "R6 epc");
        rd_chk(12'h342, 32'h80000007, "R6 cause");
        rd_chk(12'h343, 32'hDEADBEFF, "R9 tval untouched by trap");

        // R6: trap entry beats a same-cycle software cause write
        @(negedge clk);
        trap_enter = 1'b1; trap_pc = 32'h3000; trap_code = 31'd11;
        csr_req = 1'b1; csr_addr = 12'h342; csr_op = 2'd1; csr_wdata = 32'h5;
        @(posedge clk); #1;
        trap_enter = 1'b0; csr_req = 1'b0; csr_op = 2'd0;
        rd_chk(12'h342, 32'h8000000B, "R6 cause priority");
        rd_chk(12'h300, 32'h00, "R6 nested status");

        // R7: returns
        @(negedge clk); mret = 1'b1;
        @(posedge clk); #1; mret = 1'b0;
        rd_chk(12'h300, 32'h80, "R7 first return");
        @(negedge clk); mret = 1'b1;
        @(posedge clk); #1; mret = 1'b0;
        check("R7 glb_ie restored", {31'h0, glb_ie_o}, 32'h1);
        rd_chk(12'h300, 32'h88, "R7 second return");
        @(negedge clk); mret = 1'b1; trap_enter = 1'b1; trap_pc = 32'h4000; trap_code = 31'd3;
        @(posedge clk); #1; mret = 1'b0; trap_enter = 1'b0;
        rd_chk(12'h300, 32'h80, "R7 trap wins over return");
        check("R12 epc_o after trap", epc_o, 32'h4000);

        // R11: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check("R11 epc after reset", epc_o, 32'h0);
        rd_chk(12'h343, 32'h0, "R11 tval after reset");
        rd_chk(12'h305, 32'h0, "R11 tvec after reset");
        rd_chk(12'h304, 32'h0, "R11 enable after reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule